// File: doc/BRIEF.md
# Masked Multi-Bank Chip-Select Decoder

This block decodes every bus transaction against twelve bank descriptors. Each descriptor holds a base address, an address mask, a valid flag, a write-protect flag, a bus-assignment flag and a selector for the timing machine that should carry out the access. When a transaction is presented, the block raises exactly one chip-select for the winning bank and reports the machine that must run the cycle. The machine is one of five: the SDRAM controller, the general-purpose chip-select machine, or one of three programmable machines. When several banks overlap, the lowest-numbered bank wins. A write that lands on a protected bank is refused and flagged. A transaction that no bank claims is reported as a miss.

Descriptors are loaded through a plain 32-bit register write port, addressed by a 4-bit bank index and a 2-bit field select. Out of reset, bank 0 acts as a boot bank that covers the whole address space, so that code can be fetched before software sets up the map. The comparison ignores the low 15 address bits, so the smallest bank is 32 Kbytes.

Every result is registered. A request sampled on one rising edge produces its outputs for exactly the following clock cycle.

Top module: `bank_select_decoder`

## Requirements
- R1: A request sampled on a rising edge with `req_valid_i` high yields its result on `cs_o` (one bit per bank, twelve banks), `mach_o`, `prot_err_o` and `miss_o` during the following cycle only.
- R2: A bank matches when `(addr[31:15] ^ base[31:15]) & mask[31:15]` is zero. Address bits 14:0 never take part, and neither do base or mask bits 14:0 that are written.
- R3: A bank whose valid flag is clear never matches.
- R4: A bank whose local flag is 1 matches only requests with `req_local_i`=1. A bank whose local flag is 0 matches only requests with `req_local_i`=0.
- R5: When several banks match, only the lowest-numbered one is considered, and at most one `cs_o` bit is ever high.
- R6: If the winning bank is write-protected and the request is a write, no chip-select is raised and `prot_err_o` pulses. Reads of that bank proceed normally, and a higher-numbered bank never takes the write instead.
- R7: Along with a chip-select, `mach_o` carries the winning bank's machine code: 0 general-purpose, 1 SDRAM, 2/3/4 programmable machines A/B/C. Written codes 5–7 are stored as 0. Without a chip-select, `mach_o` is 0.
- R8: A request that matches no bank raises no chip-select and pulses `miss_o`.
- R9: After reset, bank 0 is valid with base 0, mask 0, machine 0, system bus and no protection. All other banks are invalid and all outputs are low.
- R10: A write on the configuration port updates the addressed bank at that clock edge. Field 0 loads the base from `cfg_wdata_i[31:15]`. Field 1 loads the mask from `cfg_wdata_i[31:15]`. Field 2 loads the attributes: bit0 valid, bit1 write-protect, bit2 local bus, bits 6:4 machine. Field 3 and bank indices 12–15 change nothing.
- R11: In a cycle that follows no sampled request, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_bank_i | input | 4 | Bank index for the descriptor write |
| cfg_field_i | input | 2 | Field select: 0 base, 1 mask, 2 attributes |
| cfg_wdata_i | input | 32 | Descriptor write data |
| req_valid_i | input | 1 | Transaction present |
| req_addr_i | input | 32 | Transaction address |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_local_i | input | 1 | 1 for the local bus, 0 for the system bus |
| cs_o | output | 12 | Registered chip-select, one bit per bank |
| mach_o | output | 3 | Machine code for the selected bank |
| prot_err_o | output | 1 | Write-protect violation pulse |
| miss_o | output | 1 | No-match pulse |

## Verification
All four results are registered once. A request driven before a rising edge therefore shows up during the cycle that follows that edge, and is gone one cycle later. The bench drives each request on a falling edge and drops it on the next falling edge. It samples the outputs at that same falling edge, half a period after the capturing edge. It samples again one falling edge later to confirm that the pulse has ended. A descriptor write is driven for one full cycle before the next request, so every request is decoded against the map as it stands after that write.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

  typedef enum logic [2:0] {
    MACH_GPCM  = 3'd0,
    MACH_SDRAM = 3'd1,
    MACH_PM_A  = 3'd2,
    MACH_PM_B  = 3'd3,
    MACH_PM_C  = 3'd4
  } mach_e;

  localparam logic [1:0] FIELD_BASE = 2'd0;
  localparam logic [1:0] FIELD_MASK = 2'd1;
  localparam logic [1:0] FIELD_ATTR = 2'd2;

  localparam int ATTR_VALID  = 0;
  localparam int ATTR_WPROT  = 1;
  localparam int ATTR_LOCAL  = 2;
  localparam int ATTR_MACH_L = 4;

  // reserved machine codes fold to the general-purpose machine
  function automatic logic [2:0] sanitize_mach(logic [2:0] code);
    return (code > 3'(MACH_PM_C)) ? 3'(MACH_GPCM) : code;
  endfunction

endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_sel_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int PAGE_W    = 15,
  parameter int IDX_W     = 4,
  parameter int BOOT_BANK = 0,
  localparam int CMP_W    = ADDR_W - PAGE_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [IDX_W-1:0]                cfg_bank_i,
  input  logic [1:0]                      cfg_field_i,
  input  logic [ADDR_W-1:0]               cfg_wdata_i,
  output logic [NUM_BANKS-1:0][CMP_W-1:0] base_o,
  output logic [NUM_BANKS-1:0][CMP_W-1:0] mask_o,
  output logic [NUM_BANKS-1:0]            valid_o,
  output logic [NUM_BANKS-1:0]            wprot_o,
  output logic [NUM_BANKS-1:0]            local_o,
  output logic [NUM_BANKS-1:0][2:0]       mach_o
);

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata_i[PAGE_W-1:ATTR_MACH_L+3], cfg_wdata_i[3]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = cfg_we_i && (cfg_bank_i == IDX_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[b]  <= '0;
        mask_o[b]  <= '0;
        valid_o[b] <= (b == BOOT_BANK);
        wprot_o[b] <= 1'b0;
        local_o[b] <= 1'b0;
        mach_o[b]  <= 3'(MACH_GPCM);
      end else if (sel) begin
        case (cfg_field_i)
          FIELD_BASE: base_o[b] <= cfg_wdata_i[ADDR_W-1:PAGE_W];
          FIELD_MASK: mask_o[b] <= cfg_wdata_i[ADDR_W-1:PAGE_W];
          FIELD_ATTR: begin
            valid_o[b] <= cfg_wdata_i[ATTR_VALID];
            wprot_o[b] <= cfg_wdata_i[ATTR_WPROT];
            local_o[b] <= cfg_wdata_i[ATTR_LOCAL];
            mach_o[b]  <= sanitize_mach(cfg_wdata_i[ATTR_MACH_L+:3]);
          end
          default: ;
        endcase
      end
    end

    // R7: a stored machine code is never a reserved one
    a_r7_mach_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mach_o[b] <= 3'(MACH_PM_C));
  end

endmodule

// File: rtl/bank_match.sv
module bank_match #(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int PAGE_W    = 15,
  localparam int CMP_W    = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            local_i,
  input  logic [NUM_BANKS-1:0][CMP_W-1:0] base_i,
  input  logic [NUM_BANKS-1:0][CMP_W-1:0] mask_i,
  input  logic [NUM_BANKS-1:0]            valid_i,
  input  logic [NUM_BANKS-1:0]            local_sel_i,
  output logic [NUM_BANKS-1:0]            hit_o
);

  logic [CMP_W-1:0] page;
  logic             unused_low;
  assign page       = addr_i[ADDR_W-1:PAGE_W];
  assign unused_low = ^addr_i[PAGE_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign hit_o[b] = valid_i[b] && (local_sel_i[b] == local_i)
                   && (((page ^ base_i[b]) & mask_i[b]) == '0);
  end

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_BANKS-1:0] hit_i,
  output logic [NUM_BANKS-1:0] win_oh_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 any_o
);

  always_comb begin
    win_oh_o  = '0;
    win_idx_o = '0;
    any_o     = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit_i[b] && !any_o) begin
        any_o       = 1'b1;
        win_oh_o[b] = 1'b1;
        win_idx_o   = IDX_W'(b);
      end
    end
  end

  // R5: the winner is one of the hitting banks
  a_r5_win_in_hits: assert final ((win_oh_o & ~hit_i) == '0);

endmodule

// File: rtl/bank_select_decoder.sv
module bank_select_decoder
  import bank_sel_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int PAGE_W    = 15,
  parameter int IDX_W     = 4,
  parameter int BOOT_BANK = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_bank_i,
  input  logic [1:0]           cfg_field_i,
  input  logic [ADDR_W-1:0]    cfg_wdata_i,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 req_write_i,
  input  logic                 req_local_i,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic [2:0]           mach_o,
  output logic                 prot_err_o,
  output logic                 miss_o
);

  localparam int CMP_W = ADDR_W - PAGE_W;

  logic [NUM_BANKS-1:0][CMP_W-1:0] base, mask;
  logic [NUM_BANKS-1:0]            valid, wprot, local_sel, hit, win_oh;
  logic [NUM_BANKS-1:0][2:0]       mach;
  logic [IDX_W-1:0]                win_idx;
  logic                            any_hit, blocked, grant;

  bank_regs #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .IDX_W(IDX_W), .BOOT_BANK(BOOT_BANK)
  ) i_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_bank_i, .cfg_field_i, .cfg_wdata_i,
    .base_o(base), .mask_o(mask), .valid_o(valid), .wprot_o(wprot),
    .local_o(local_sel), .mach_o(mach)
  );

  bank_match #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_match (
    .addr_i(req_addr_i), .local_i(req_local_i), .base_i(base), .mask_i(mask),
    .valid_i(valid), .local_sel_i(local_sel), .hit_o(hit)
  );

  prio_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) i_pick (
    .hit_i(hit), .win_oh_o(win_oh), .win_idx_o(win_idx), .any_o(any_hit)
  );

  // protection of the winner is final: no fall-through to higher banks
  assign blocked = req_valid_i && any_hit && req_write_i && wprot[win_idx];
  assign grant   = req_valid_i && any_hit && !blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o       <= '0;
      mach_o     <= 3'(MACH_GPCM);
      prot_err_o <= 1'b0;
      miss_o     <= 1'b0;
    end else begin
      cs_o       <= grant ? win_oh : '0;
      mach_o     <= grant ? mach[win_idx] : 3'(MACH_GPCM);
      prot_err_o <= blocked;
      miss_o     <= req_valid_i && !any_hit;
    end
  end

  a_r5_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  a_r8_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (cs_o == '0) && !prot_err_o);

  a_r6_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |-> (cs_o == '0));

  a_r6_err_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i |=> !prot_err_o);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (cs_o == '0) && !miss_o && !prot_err_o && (mach_o == 3'(MACH_GPCM)));

  a_r7_mach_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o == '0) |-> (mach_o == 3'(MACH_GPCM)));

  a_r1_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> $countones({cs_o != '0, prot_err_o, miss_o}) == 1);

endmodule

// File: tb/test_bank_select_decoder.sv
module test_bank_select_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_bank = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_local = 1'b0;
  logic [11:0] cs;
  logic [2:0]  mach;
  logic        prot_err, miss;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_select_decoder i_bank_select_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_bank_i(cfg_bank),
    .cfg_field_i(cfg_field), .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_local_i(req_local),
    .cs_o(cs), .mach_o(mach), .prot_err_o(prot_err), .miss_o(miss)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int bank, input logic [1:0] field, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 4'(bank); cfg_field = field; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] attr(bit v, bit wp, bit loc, int m);
    return {25'd0, 3'(m), 1'b0, loc, wp, v};
  endfunction

  task automatic setup_bank(input int bank, input logic [31:0] base, input logic [31:0] mask,
                            input logic [31:0] a);
    cfg_write(bank, 2'd0, base);
    cfg_write(bank, 2'd1, mask);
    cfg_write(bank, 2'd2, a);
  endtask

  // exp_bank < 0 means no chip-select expected
  task automatic request(input logic [31:0] addr, input bit wr, input bit loc,
                         input int exp_bank, input int exp_mach, input bit exp_err,
                         input bit exp_miss, input string req);
    logic [11:0] exp_cs;
    exp_cs = (exp_bank < 0) ? 12'd0 : 12'(1) << exp_bank;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_local = loc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cs == exp_cs, {req, " cs"}, 32'(cs), 32'(exp_cs));
    chk(mach == 3'(exp_mach), {req, " mach"}, 32'(mach), 32'(exp_mach));
    chk(prot_err == exp_err, {req, " prot_err"}, 32'(prot_err), 32'(exp_err));
    chk(miss == exp_miss, {req, " miss"}, 32'(miss), 32'(exp_miss));
    @(negedge clk);
    chk(cs == 12'd0 && !prot_err && !miss && mach == 3'd0, {req, " R1 pulse ends"},
        {18'd0, cs, prot_err, miss}, 32'd0);
  endtask

  task automatic t_reset;
    chk(cs == 12'd0 && !prot_err && !miss, "R9 reset outputs", 32'(cs), 32'd0);
    request(32'h1234_5678, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, "R9 boot bank read");
    request(32'hFFFF_FFFC, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, "R9 boot bank write");
    request(32'h0000_0100, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, "R9 boot bank system only");
  endtask

  task automatic t_invalid;
    cfg_write(0, 2'd2, attr(0, 0, 0, 0));
    request(32'h1234_5678, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R3 invalid bank");
    setup_bank(4, 32'h6000_0000, 32'hF000_0000, attr(0, 0, 0, 1));
    request(32'h6000_0000, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R3 configured but invalid");
  endtask

  task automatic t_priority;
    setup_bank(5, 32'h4000_0000, 32'hC000_0000, attr(1, 0, 0, 3));
    setup_bank(2, 32'h4000_0000, 32'hF000_0000, attr(1, 0, 0, 1));
    request(32'h4123_4567, 1'b0, 1'b0, 2, 1, 1'b0, 1'b0, "R5 lowest bank wins");
    request(32'h7000_0000, 1'b0, 1'b0, 5, 3, 1'b0, 1'b0, "R7 machine B");
    request(32'h8000_0000, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R8 no match");
  endtask

  task automatic t_mask;
    setup_bank(3, 32'h1000_7FFF, 32'hFFFF_8123, attr(1, 0, 0, 2));
    request(32'h1000_0000, 1'b0, 1'b0, 3, 2, 1'b0, 1'b0, "R2 32K bank low edge");
    request(32'h1000_7FFF, 1'b0, 1'b0, 3, 2, 1'b0, 1'b0, "R2 32K bank high edge");
    request(32'h1000_8000, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R2 just past 32K");
    request(32'h0FFF_FFFF, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R2 just below base");
  endtask

  task automatic t_bus;
    setup_bank(7, 32'h2000_0000, 32'hF000_0000, attr(1, 0, 1, 4));
    request(32'h2000_0010, 1'b0, 1'b1, 7, 4, 1'b0, 1'b0, "R4 local bus hit");
    request(32'h2000_0010, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R4 system bus miss");
  endtask

  task automatic t_wprot;
    setup_bank(10, 32'h9000_0000, 32'hF000_0000, attr(1, 0, 0, 1));
    setup_bank(9, 32'h9000_0000, 32'hF000_0000, attr(1, 1, 0, 2));
    request(32'h9000_1000, 1'b0, 1'b0, 9, 2, 1'b0, 1'b0, "R6 read of protected bank");
    request(32'h9000_1000, 1'b1, 1'b0, -1, 0, 1'b1, 1'b0, "R6 write blocked, no fallthrough");
    setup_bank(8, 32'hA000_0000, 32'hF000_0000, attr(1, 0, 0, 1));
    request(32'hA000_0040, 1'b1, 1'b0, 8, 1, 1'b0, 1'b0, "R6 write to open bank");
  endtask

  task automatic t_reserved_mach;
    setup_bank(11, 32'hB000_0000, 32'hF000_0000, attr(1, 0, 0, 6));
    request(32'hB000_0000, 1'b0, 1'b0, 11, 0, 1'b0, 1'b0, "R7 reserved code stored as 0");
  endtask

  task automatic t_cfg_ignored;
    cfg_write(3, 2'd3, 32'h0000_0000);
    request(32'h1000_0004, 1'b0, 1'b0, 3, 2, 1'b0, 1'b0, "R10 field 3 ignored");
    cfg_write(14, 2'd2, attr(1, 0, 0, 0));
    cfg_write(12, 2'd2, attr(1, 0, 0, 0));
    request(32'hE000_0000, 1'b0, 1'b0, -1, 0, 1'b0, 1'b1, "R10 bank index 12+ ignored");
    cfg_write(2, 2'd0, 32'h5000_0000);
    request(32'h5000_0000, 1'b0, 1'b0, 2, 1, 1'b0, 1'b0, "R10 base rewrite takes effect");
  endtask

  task automatic t_idle;
    repeat (3) @(negedge clk);
    chk(cs == 12'd0 && !prot_err && !miss && mach == 3'd0, "R11 idle quiet",
        {18'd0, cs, prot_err, miss}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_invalid();
    t_priority();
    t_mask();
    t_bus();
    t_wprot();
    t_reserved_mach();
    t_cfg_ignored();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule